// File: doc/BRIEF.md
# Cartridge four-pin general-purpose I/O port

This block is a tiny register file on the cartridge address bus that drives four general-purpose pins toward a serial peripheral, such as a clock chip, and takes back what that peripheral presents. Software chooses, pin by pin, whether each pin is an output or an input through a direction register. Writes to the data register reach the pins only on output positions. A one-bit enable decides whether the port answers reads with real contents or with zeros.

Each accepted data write sends the masked pin pattern to the peripheral together with a single-cycle strobe. The peripheral answers with a 4-bit pattern during that strobe cycle, and the port stores that pattern as its data contents. Reads show only the bits of input pins. Writes may be 16 or 32 bits wide. Reads may be 8 or 16 bits wide and come back on the cycle after the request. Accesses outside the three register offsets are left to the ROM path through a hit flag.

Top module: `cart_gpio_port`

## Requirements
- R1: After reset the stored data is 0000, the direction is 1111 (all outputs), the enable is 0, `pin_out` is 0000 and `pin_strobe` is low.
- R2: While the enable is 0, an 8- or 16-bit read at any of the three register offsets returns `bus_rdata` = 0 with `bus_hit` = 1.
- R3: A 16-bit write (`bus_size` = 1) at offset 0xC4 is a data write from bits 3:0. At 0xC6 it loads the direction from bits 3:0. At 0xC8 it loads the enable from bit 0. All other write bits are ignored.
- R4: On a data write, `pin_out` becomes write bits 3:0 ANDed with the direction held before that write. On the cycle after the write, `pin_strobe` is high for exactly one cycle.
- R5: The stored data is loaded from `pin_in` on the cycle in which `pin_strobe` is high, and changes at no other time.
- R6: With the enable at 1, a read at 0xC4 returns the stored data ANDed with the inverted direction in bits 3:0, with the upper bits zero.
- R7: With the enable at 1, a read at 0xC6 returns the direction in bits 3:0, and a read at 0xC8 returns the enable in bit 0. The upper bits are zero.
- R8: A 32-bit write (`bus_size` = 2) at 0xC4 is a data write from bits 3:0, masked by the old direction, and loads the direction from bits 19:16. A 32-bit write at 0xC6 loads the direction from bits 3:0 and the enable from bit 16. A 32-bit write at 0xC8 is ignored.
- R9: Byte writes (`bus_size` = 0) and writes with `bus_size` = 3 leave data, direction and enable unchanged and raise no strobe.
- R10: Writes to any address other than ROM base + 0xC4/0xC6/0xC8 are ignored. Reads there, and 32-bit reads anywhere, give `bus_hit` = 0 with `bus_rdata` = 0.
- R11: `bus_hit` and `bus_rdata` are registered. They reflect the read requested in the previous cycle and are 0 in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request this cycle |
| bus_rd | input | 1 | Read request this cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | RD_W | Read data, one cycle after the request |
| bus_hit | output | 1 | Read served by this port, one cycle after the request |
| pin_out | output | PINS | Pin pattern presented to the peripheral |
| pin_strobe | output | 1 | One-cycle pulse marking a new pin pattern |
| pin_in | input | PINS | Pattern returned by the peripheral |

## Verification
A wrong direction register shows up at once in two places: in `pin_out` on the next data write, and in the data read-back, where output bits would leak through. A stuck enable turns every register read into zeros, or turns zeros into real contents, on the very next read. A capture taken at the wrong cycle leaves a stale peripheral pattern in the data register, and it becomes visible on the first data read after the strobe. A decode error appears as a spurious strobe, a changed register, or a wrong `bus_hit` on the cycle after the offending access.

// File: rtl/cgp_pkg.sv
package cgp_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } bus_size_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cgp_decode.sv
module cgp_decode
  import cgp_pkg::*;
#(
  parameter int                 ADDR_W = 32,
  parameter logic [ADDR_W-1:0]  A_DATA = '0,
  parameter logic [ADDR_W-1:0]  A_DIR  = '0,
  parameter logic [ADDR_W-1:0]  A_CTRL = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              wr,
  input  logic              rd,
  output reg_sel_e          sel,
  output logic              we_data,
  output logic              we_dir_lo,
  output logic              we_dir_hi,
  output logic              we_ctrl_lo,
  output logic              we_ctrl_hi,
  output logic              rd_hit
);
  bus_size_e sz;
  logic is_byte, is_half, is_word;

  always_comb begin
    sz      = bus_size_e'(size);
    is_byte = (sz == SZ_BYTE);
    is_half = (sz == SZ_HALF);
    is_word = (sz == SZ_WORD);
    if (addr == A_DATA)      sel = SEL_DATA;
    else if (addr == A_DIR)  sel = SEL_DIR;
    else if (addr == A_CTRL) sel = SEL_CTRL;
    else                     sel = SEL_NONE;

    we_data    = wr && (sel == SEL_DATA) && (is_half || is_word);
    we_dir_lo  = wr && (sel == SEL_DIR)  && (is_half || is_word);
    we_dir_hi  = wr && (sel == SEL_DATA) && is_word;
    we_ctrl_lo = wr && (sel == SEL_CTRL) && is_half;
    we_ctrl_hi = wr && (sel == SEL_DIR)  && is_word;
    rd_hit     = rd && (sel != SEL_NONE) && (is_byte || is_half);
  end
endmodule

// File: rtl/cgp_regs.sv
module cgp_regs #(
  parameter int PINS    = 4,
  parameter int BUS_W   = 32,
  parameter int HI_LANE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_data,
  input  logic             we_dir_lo,
  input  logic             we_dir_hi,
  input  logic             we_ctrl_lo,
  input  logic             we_ctrl_hi,
  input  logic [BUS_W-1:0] wdata,
  input  logic [PINS-1:0]  pin_in,
  output logic [PINS-1:0]  data_q,
  output logic [PINS-1:0]  dir_q,
  output logic             ctrl_q,
  output logic [PINS-1:0]  pin_out,
  output logic             pin_strobe
);
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic d_bit, r_bit, o_bit;

    always_ff @(posedge clk) begin
      if (rst) begin
        d_bit <= 1'b0;
        r_bit <= 1'b1;
        o_bit <= 1'b0;
      end else begin
        if (we_data)        o_bit <= wdata[i] & r_bit;
        if (we_dir_lo)      r_bit <= wdata[i];
        else if (we_dir_hi) r_bit <= wdata[HI_LANE+i];
        if (pin_strobe)     d_bit <= pin_in[i];
      end
    end

    assign data_q[i]  = d_bit;
    assign dir_q[i]   = r_bit;
    assign pin_out[i] = o_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= 1'b0;
      pin_strobe <= 1'b0;
    end else begin
      pin_strobe <= we_data;
      if (we_ctrl_lo)      ctrl_q <= wdata[0];
      else if (we_ctrl_hi) ctrl_q <= wdata[HI_LANE];
    end
  end

  AST_STROBE_MASK: assert property (@(posedge clk) disable iff (rst)
    pin_strobe |-> ((pin_out & ~$past(dir_q)) == '0)); // R4

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(pin_strobe) && !$past(rst)) |-> (data_q == $past(data_q))); // R5
endmodule

// File: rtl/cgp_rdmux.sv
module cgp_rdmux
  import cgp_pkg::*;
#(
  parameter int PINS = 4,
  parameter int RD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_hit,
  input  reg_sel_e        sel,
  input  logic [PINS-1:0] data_q,
  input  logic [PINS-1:0] dir_q,
  input  logic            ctrl_q,
  output logic [RD_W-1:0] rdata,
  output logic            hit
);
  logic [RD_W-1:0] val;

  always_comb begin
    val = '0;
    unique case (sel)
      SEL_DATA: val[PINS-1:0] = data_q & ~dir_q;
      SEL_DIR:  val[PINS-1:0] = dir_q;
      SEL_CTRL: val[0]        = ctrl_q;
      default:  val           = '0;
    endcase
    if (!ctrl_q) val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      hit   <= 1'b0;
    end else begin
      hit   <= rd_hit;
      rdata <= rd_hit ? val : '0;
    end
  end

  AST_GATED_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rd_hit && !ctrl_q) |-> (rdata == '0)); // R2

  AST_INPUT_ONLY: assert property (@(posedge clk) disable iff (rst)
    $past(rd_hit && (sel == SEL_DATA)) |-> ((rdata[PINS-1:0] & $past(dir_q)) == '0)); // R6
endmodule

// File: rtl/cart_gpio_port.sv
module cart_gpio_port
  import cgp_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] ROM_BASE = 32'h0800_0000,
  parameter logic [ADDR_W-1:0] OFS_DATA = 'h0C4,
  parameter logic [ADDR_W-1:0] OFS_DIR  = 'h0C6,
  parameter logic [ADDR_W-1:0] OFS_CTRL = 'h0C8,
  parameter int                PINS     = 4,
  parameter int                BUS_W    = 32,
  parameter int                RD_W     = 16,
  parameter int                HI_LANE  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [RD_W-1:0]   bus_rdata,
  output logic              bus_hit,
  output logic [PINS-1:0]   pin_out,
  output logic              pin_strobe,
  input  logic [PINS-1:0]   pin_in
);
  localparam logic [ADDR_W-1:0] A_DATA = ROM_BASE + OFS_DATA;
  localparam logic [ADDR_W-1:0] A_DIR  = ROM_BASE + OFS_DIR;
  localparam logic [ADDR_W-1:0] A_CTRL = ROM_BASE + OFS_CTRL;

  reg_sel_e        sel;
  logic            we_data, we_dir_lo, we_dir_hi, we_ctrl_lo, we_ctrl_hi, rd_hit;
  logic [PINS-1:0] data_q, dir_q;
  logic            ctrl_q;

  cgp_decode #(
    .ADDR_W(ADDR_W), .A_DATA(A_DATA), .A_DIR(A_DIR), .A_CTRL(A_CTRL)
  ) u_decode (
    .addr(bus_addr), .size(bus_size), .wr(bus_wr), .rd(bus_rd),
    .sel(sel), .we_data(we_data), .we_dir_lo(we_dir_lo), .we_dir_hi(we_dir_hi),
    .we_ctrl_lo(we_ctrl_lo), .we_ctrl_hi(we_ctrl_hi), .rd_hit(rd_hit)
  );

  cgp_regs #(
    .PINS(PINS), .BUS_W(BUS_W), .HI_LANE(HI_LANE)
  ) u_regs (
    .clk(clk), .rst(rst),
    .we_data(we_data), .we_dir_lo(we_dir_lo), .we_dir_hi(we_dir_hi),
    .we_ctrl_lo(we_ctrl_lo), .we_ctrl_hi(we_ctrl_hi),
    .wdata(bus_wdata), .pin_in(pin_in),
    .data_q(data_q), .dir_q(dir_q), .ctrl_q(ctrl_q),
    .pin_out(pin_out), .pin_strobe(pin_strobe)
  );

  cgp_rdmux #(
    .PINS(PINS), .RD_W(RD_W)
  ) u_rdmux (
    .clk(clk), .rst(rst), .rd_hit(rd_hit), .sel(sel),
    .data_q(data_q), .dir_q(dir_q), .ctrl_q(ctrl_q),
    .rdata(bus_rdata), .hit(bus_hit)
  );

  AST_BYTE_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr && (bus_size == 2'd0)) |->
      ((dir_q == $past(dir_q)) && (ctrl_q == $past(ctrl_q)) && !pin_strobe)); // R9

  AST_WORD_RD_MISS: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && (bus_size == 2'd2)) |-> (!bus_hit && (bus_rdata == '0))); // R10

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> (!bus_hit && (bus_rdata == '0))); // R11
endmodule

// File: tb/test_cart_gpio_port.sv
`timescale 1ns/1ps
module test_cart_gpio_port;
  localparam logic [31:0] BASE = 32'h0800_0000;
  localparam logic [31:0] AD = BASE + 32'h0C4;
  localparam logic [31:0] AR = BASE + 32'h0C6;
  localparam logic [31:0] AC = BASE + 32'h0C8;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_hit;
  logic [3:0]  pin_out, pin_in;
  logic        pin_strobe;
  logic [3:0]  per_xor;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [3:0] m_data, m_dir, m_pout;
  logic       m_ctrl;

  always #2 clk = ~clk;

  assign pin_in = pin_out ^ per_xor;

  cart_gpio_port i_cart_gpio_port (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_hit(bus_hit),
    .pin_out(pin_out), .pin_strobe(pin_strobe), .pin_in(pin_in)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [16:0] exp_read(input logic [31:0] a, input logic [1:0] s);
    logic [15:0] v;
    v = '0;
    if (s > 2'd1 || !(a == AD || a == AR || a == AC)) return 17'd0;
    if (m_ctrl) begin
      if (a == AD)      v[3:0] = m_data & ~m_dir;
      else if (a == AR) v[3:0] = m_dir;
      else              v[0]   = m_ctrl;
    end
    return {1'b1, v};
  endfunction

  task automatic do_write(input logic [31:0] a, input logic [1:0] s,
                          input logic [31:0] w, input string req);
    bit is_data;
    bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = w;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    is_data = (a == AD) && (s == 2'd1 || s == 2'd2);
    if (is_data) begin
      m_pout = w[3:0] & m_dir;
      chk(req, "strobe after data write", 32'(pin_strobe), 32'd1);
      chk(req, "pin_out masked", 32'(pin_out), 32'(m_pout));
    end else begin
      chk(req, "no strobe", 32'(pin_strobe), 32'd0);
    end
    if (a == AR && (s == 2'd1 || s == 2'd2)) m_dir = w[3:0];
    if (a == AD && s == 2'd2)                m_dir = w[19:16];
    if (a == AC && s == 2'd1)                m_ctrl = w[0];
    if (a == AR && s == 2'd2)                m_ctrl = w[16];
    @(posedge clk);
    @(negedge clk);
    if (is_data) begin
      m_data = m_pout ^ per_xor;
      chk("R4", "strobe one cycle", 32'(pin_strobe), 32'd0);
    end
  endtask

  task automatic do_read(input logic [31:0] a, input logic [1:0] s, input string req);
    logic [16:0] e;
    e = exp_read(a, s);
    bus_rd = 1'b1; bus_addr = a; bus_size = s;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, "hit", 32'(bus_hit), 32'(e[16]));
    chk(req, "rdata", 32'(bus_rdata), 32'(e[15:0]));
  endtask

  initial begin
    logic [31:0] addrs [6];
    addrs[0] = AD; addrs[1] = AR; addrs[2] = AC;
    addrs[3] = BASE + 32'h0CA; addrs[4] = BASE + 32'h0C2; addrs[5] = BASE + 32'h0C5;
    void'($urandom(32'h0C0FFEE5));
    rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_size = 2'd1;
    bus_wdata = '0; per_xor = 4'h3;
    m_data = 4'h0; m_dir = 4'hF; m_ctrl = 1'b0; m_pout = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1", "pin_out after reset", 32'(pin_out), 32'd0);
    chk("R1", "strobe after reset", 32'(pin_strobe), 32'd0);
    // R2 gated reads
    do_read(AD, 2'd1, "R2");
    do_read(AR, 2'd0, "R2");
    do_read(AC, 2'd1, "R2");
    // R3 enable via halfword, upper bits ignored
    do_write(AC, 2'd1, 32'hFFFF_FFFF, "R3");
    do_read(AR, 2'd1, "R1");
    do_read(AC, 2'd1, "R7");
    do_read(AD, 2'd1, "R6");
    // R4/R5 data write and capture
    do_write(AD, 2'd1, 32'h0000_FFFA, "R4");
    do_read(AD, 2'd1, "R6");
    do_write(AR, 2'd1, 32'hFFF3, "R3");
    do_read(AD, 2'd0, "R5");
    do_read(AR, 2'd1, "R7");
    // R8 word writes
    do_write(AD, 2'd2, 32'h000C_0005, "R8");
    do_read(AR, 2'd1, "R8");
    do_read(AD, 2'd1, "R8");
    do_write(AR, 2'd2, 32'h0000_0006, "R8");
    do_read(AR, 2'd1, "R2");
    do_write(AR, 2'd2, 32'h0001_0009, "R8");
    do_read(AC, 2'd1, "R8");
    do_write(AC, 2'd2, 32'h0000_0000, "R8");
    do_read(AC, 2'd1, "R8");
    // R9 byte writes ignored
    do_write(AC, 2'd0, 32'h0, "R9");
    do_write(AR, 2'd0, 32'hFF, "R9");
    do_write(AD, 2'd0, 32'hF, "R9");
    do_write(AD, 2'd3, 32'hF, "R9");
    do_read(AR, 2'd1, "R9");
    do_read(AD, 2'd1, "R9");
    // R10 other offsets, word reads
    do_write(BASE + 32'h0CA, 2'd1, 32'h1, "R10");
    do_write(BASE + 32'h0C2, 2'd2, 32'hFFFF_FFFF, "R10");
    do_read(BASE + 32'h0CA, 2'd1, "R10");
    do_read(AD, 2'd2, "R10");
    do_read(AR, 2'd1, "R10");
    // R11 idle cycle after a read
    @(posedge clk);
    @(negedge clk);
    chk("R11", "idle hit", 32'(bus_hit), 32'd0);
    chk("R11", "idle rdata", 32'(bus_rdata), 32'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic [1:0]  s;
      a = addrs[$urandom_range(5, 0)];
      s = 2'($urandom_range(3, 0));
      if ($urandom_range(7, 0) == 0) per_xor = 4'($urandom());
      if ($urandom_range(1, 0) == 1) do_write(a, s, $urandom(), "R8");
      else                           do_read(a, s, "R6");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule